// File: doc/BRIEF.md
# Rotating Multi-Channel State Scheduler

This block is the scheduling core for a group of I/O channels that share one memory-access engine and one device-side engine. Instead of each channel owning its own controller, every channel's state record (its identity and the fill level of its small data buffer) circulates around a ring of registers and moves one slot per clock. Engines sit at fixed slots of the ring. Each engine sees a different channel every cycle and may rewrite the record in front of it. The rewritten record is what moves on to the next slot.

The memory engine sits at slot 0 and meets every channel once per rotation. During a rotation it scans the channels for a priority that comes from buffer occupancy. An output channel, which carries data from memory to the device, gains priority as its buffer empties. An input channel gains priority as its buffer fills. At the end of the rotation the memory engine raises one word request for the winner. The device engine sits at the middle two slots and works on alternate cycles. It moves one byte, or two on a double-width channel, between the buffer and the device whenever the device is ready. Main memory and the devices are modelled by simple request/acknowledge and ready ports.

Top module: `chan_sched_ring`

## Requirements
- R1: After reset every buffer level is zero, `mem_req` is 0 and `dev_vld` is 0.
- R2: The ring moves one slot per cycle. At reset slot p holds channel p, so the memory engine at slot 0 sees channel (NCH − k) mod NCH in the k-th cycle after reset. That is channel 0, then NCH−1, and so on down, which brings each channel back once every NCH cycles.
- R3: The device engine acts only in even cycles (k even), on the channels at slots NCH/2 and NCH/2+1. `dev_vld[0]` and `dev_ch0` report a transfer at slot NCH/2. `dev_vld[1]` and `dev_ch1` report one at slot NCH/2+1. Both appear on the clock edge that ends that cycle.
- R4: A device transfer needs the channel to be enabled (`ch_en`) and its device to be ready (`dev_rdy`). The step is 2 bytes when `ch_wide` is set and 1 byte when it is clear. An output channel (`ch_out`=1) needs level ≥ step and its level drops by the step. An input channel needs level + step ≤ DEPTH and its level rises by the step.
- R5: The priority of an output channel is DEPTH − level. The priority of an input channel is its level. A priority below WORD (4 bytes) counts as 0. A disabled channel has priority 0.
- R6: Each rotation runs through the cycles with phase 0 to NCH−1, where phase is k mod NCH. On the edge that ends phase NCH−1, if the engine is idle and some channel has nonzero priority, `mem_req` rises with `mem_ch` set to the channel of highest priority. Ties go to the lowest channel number.
- R7: Only one request is outstanding at a time. `mem_req`, `mem_ch` and `mem_wr` hold until `mem_ack` is seen.
- R8: After the acknowledge, the channel stays locked. It is left out of the scan and no new request is raised. The lock ends when the channel next reaches slot 0. There its level changes by one word (+4 for output, −4 for input).
- R9: `mem_wr` is 1 for an input channel (buffer to memory) and 0 for an output channel.
- R10: While a channel's request is outstanding or locked, the device engine keeps moving its data, so its priority can change while the transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Per-channel enable |
| ch_out | input | NCH | Per-channel direction, 1 = output (memory to device) |
| ch_wide | input | NCH | Per-channel double-width device interface |
| dev_rdy | input | NCH | Device ready to send or accept data |
| mem_ack | input | 1 | Memory acknowledges the outstanding word request |
| mem_req | output | 1 | Word request to memory |
| mem_ch | output | log2(NCH) | Channel of the request |
| mem_wr | output | 1 | 1 = write buffer word to memory, 0 = read word into buffer |
| dev_vld | output | 2 | Device transfer happened at device port 0 / 1 |
| dev_ch0 | output | log2(NCH) | Channel served by device port 0 |
| dev_ch1 | output | log2(NCH) | Channel served by device port 1 |

## Verification
The scheduler is driven with four channel populations. The first has all output channels on narrow ports with instant acknowledge, which shows whether levels drain and refill in step with the rotation. The second has all input channels with mixed widths, which separates one-byte from two-byte steps and checks the write direction. The third mixes directions, widths, disabled channels and idle devices under a long acknowledge delay, so levels move while a channel is locked and the priority order shifts from one rotation to the next. The fourth has a single wide input channel, which exposes the window timing with no arbitration at all. A directed run with all channels tied at equal priority pins down the first-request cycle, the lowest-number tie rule, and the length of the lock after the acknowledge.

// File: rtl/chsr_pkg.sv
package chsr_pkg;
  // Service priority: room left (output) or data held (input); below one word it is zero.
  function automatic int buf_prio(int lvl, logic is_out, int depth, int word);
    int amount;
    amount = is_out ? (depth - lvl) : lvl;
    return (amount >= word) ? amount : 0;
  endfunction

  // Bytes moved per device access.
  function automatic int dev_step(logic wide);
    return wide ? 2 : 1;
  endfunction
endpackage

// File: rtl/chsr_ring.sv
module chsr_ring #(
  parameter int NCH     = 16,
  parameter int LVL_W   = 5,
  parameter int MEM_POS = 0,
  parameter int DEV_POS = 8,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [CH_W-1:0]             m_id,
  output logic [LVL_W-1:0]            m_lvl,
  input  logic [LVL_W-1:0]            m_lvl_nx,
  output logic [1:0][CH_W-1:0]        d_id,
  output logic [1:0][LVL_W-1:0]       d_lvl,
  input  logic [1:0][LVL_W-1:0]       d_lvl_nx
);
  logic [CH_W-1:0]  rid  [NCH];
  logic [LVL_W-1:0] rlvl [NCH];
  logic [LVL_W-1:0] leave [NCH];   // record level as it leaves each slot

  for (genvar p = 0; p < NCH; p++) begin : g_slot
    localparam int SRC = (p + NCH - 1) % NCH;
    if (p == MEM_POS) begin : g_mem
      assign leave[p] = m_lvl_nx;
    end else if (p == DEV_POS) begin : g_d0
      assign leave[p] = d_lvl_nx[0];
    end else if (p == DEV_POS + 1) begin : g_d1
      assign leave[p] = d_lvl_nx[1];
    end else begin : g_pass
      assign leave[p] = rlvl[p];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rid[p]  <= CH_W'(p);
        rlvl[p] <= '0;
      end else begin
        rid[p]  <= rid[SRC];
        rlvl[p] <= leave[SRC];
      end
    end
  end

  assign m_id     = rid[MEM_POS];
  assign m_lvl    = rlvl[MEM_POS];
  assign d_id[0]  = rid[DEV_POS];
  assign d_id[1]  = rid[DEV_POS + 1];
  assign d_lvl[0] = rlvl[DEV_POS];
  assign d_lvl[1] = rlvl[DEV_POS + 1];
endmodule

// File: rtl/chsr_mem.sv
module chsr_mem
  import chsr_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int WORD  = 4,
  parameter int LVL_W = 5,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  ph,
  input  logic [CH_W-1:0]  id,
  input  logic [LVL_W-1:0] lvl,
  output logic [LVL_W-1:0] lvl_nx,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH-1:0]   ch_out,
  input  logic             mem_ack,
  output logic             mem_req,
  output logic [CH_W-1:0]  mem_ch,
  output logic             mem_wr,
  output logic             pend,
  output logic             apply
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

  logic [LVL_W-1:0] best_p, cur_p, nb_p, p0;
  logic [CH_W-1:0]  best_id, nb_id;
  logic             locked, take, issue;

  always_comb begin
    locked = (mem_req || pend) && (id == mem_ch);
    p0     = (ch_en[id] && !locked)
             ? LVL_W'(buf_prio(32'(lvl), ch_out[id], DEPTH, WORD)) : '0;
    cur_p  = (ph == '0) ? '0 : best_p;
    take   = (p0 != '0) && ((p0 > cur_p) || ((p0 == cur_p) && (id < best_id)));
    nb_p   = take ? p0 : cur_p;
    nb_id  = take ? id : best_id;
    apply  = pend && (id == mem_ch);
    lvl_nx = apply ? (ch_out[id] ? lvl + LVL_W'(WORD) : lvl - LVL_W'(WORD)) : lvl;
    issue  = (ph == LAST) && !mem_req && !pend && (nb_p != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req <= 1'b0;
      mem_ch  <= '0;
      mem_wr  <= 1'b0;
      pend    <= 1'b0;
      best_p  <= '0;
      best_id <= '0;
    end else begin
      best_p  <= nb_p;
      best_id <= nb_id;
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        pend    <= 1'b1;
      end else if (issue) begin
        mem_req <= 1'b1;
        mem_ch  <= nb_id;
        mem_wr  <= !ch_out[nb_id];
      end
      if (apply) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/chsr_dev.sv
module chsr_dev
  import chsr_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [1:0][CH_W-1:0]  d_id,
  input  logic [1:0][LVL_W-1:0] d_lvl,
  output logic [1:0][LVL_W-1:0] d_lvl_nx,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH-1:0]        ch_out,
  input  logic [NCH-1:0]        ch_wide,
  input  logic [NCH-1:0]        dev_rdy,
  output logic [1:0]            dev_vld,
  output logic [1:0][CH_W-1:0]  dev_ch
);
  for (genvar j = 0; j < 2; j++) begin : g_port
    logic [LVL_W-1:0] step;
    logic             fits, fire;
    logic [CH_W-1:0]  cid;

    always_comb begin
      cid  = d_id[j];
      step = LVL_W'(dev_step(ch_wide[cid]));
      fits = ch_out[cid] ? (d_lvl[j] >= step)
                         : (({1'b0, d_lvl[j]} + {1'b0, step}) <= (LVL_W + 1)'(DEPTH));
      fire = active && ch_en[cid] && dev_rdy[cid] && fits;
      d_lvl_nx[j] = fire ? (ch_out[cid] ? d_lvl[j] - step : d_lvl[j] + step) : d_lvl[j];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dev_vld[j] <= 1'b0;
        dev_ch[j]  <= '0;
      end else begin
        dev_vld[j] <= fire;
        if (fire) dev_ch[j] <= cid;
      end
    end
  end
endmodule

// File: rtl/chan_sched_ring.sv
module chan_sched_ring #(
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int WORD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH-1:0]          ch_out,
  input  logic [NCH-1:0]          ch_wide,
  input  logic [NCH-1:0]          dev_rdy,
  input  logic                    mem_ack,
  output logic                    mem_req,
  output logic [$clog2(NCH)-1:0]  mem_ch,
  output logic                    mem_wr,
  output logic [1:0]              dev_vld,
  output logic [$clog2(NCH)-1:0]  dev_ch0,
  output logic [$clog2(NCH)-1:0]  dev_ch1
);
  localparam int CH_W    = $clog2(NCH);
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int MEM_POS = 0;
  localparam int DEV_POS = NCH / 2;

  logic [CH_W-1:0]        ph;
  logic [CH_W-1:0]        ring_m_id;
  logic [LVL_W-1:0]       ring_m_lvl, ring_m_nx;
  logic [1:0][CH_W-1:0]   ring_d_id;
  logic [1:0][LVL_W-1:0]  ring_d_lvl, ring_d_nx;
  logic [1:0][CH_W-1:0]   dev_ch;
  logic                   mem_pend, mem_apply;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= (ph == CH_W'(NCH - 1)) ? '0 : ph + 1'b1;
  end

  chsr_ring #(.NCH(NCH), .LVL_W(LVL_W), .MEM_POS(MEM_POS), .DEV_POS(DEV_POS)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .m_id(ring_m_id), .m_lvl(ring_m_lvl), .m_lvl_nx(ring_m_nx),
    .d_id(ring_d_id), .d_lvl(ring_d_lvl), .d_lvl_nx(ring_d_nx));

  chsr_mem #(.NCH(NCH), .DEPTH(DEPTH), .WORD(WORD), .LVL_W(LVL_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .id(ring_m_id), .lvl(ring_m_lvl), .lvl_nx(ring_m_nx),
    .ch_en(ch_en), .ch_out(ch_out), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_ch(mem_ch), .mem_wr(mem_wr),
    .pend(mem_pend), .apply(mem_apply));

  chsr_dev #(.NCH(NCH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_dev (
    .clk(clk), .rst_n(rst_n), .active(~ph[0]),
    .d_id(ring_d_id), .d_lvl(ring_d_lvl), .d_lvl_nx(ring_d_nx),
    .ch_en(ch_en), .ch_out(ch_out), .ch_wide(ch_wide), .dev_rdy(dev_rdy),
    .dev_vld(dev_vld), .dev_ch(dev_ch));

  assign dev_ch0 = dev_ch[0];
  assign dev_ch1 = dev_ch[1];
endmodule

// File: rtl/chsr_checker.sv
module chsr_checker #(
  parameter int NCH   = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  ch_en,
  input logic [NCH-1:0]  ch_out,
  input logic [NCH-1:0]  dev_rdy,
  input logic            mem_ack,
  input logic            mem_req,
  input logic [CH_W-1:0] mem_ch,
  input logic            mem_wr,
  input logic [1:0]      dev_vld,
  input logic [CH_W-1:0] dev_ch0,
  input logic [CH_W-1:0] ph,
  input logic [CH_W-1:0] ring_m_id,
  input logic            mem_pend,
  input logic            mem_apply
);
  logic            started;
  logic [CH_W-1:0] m_id_q;
  logic [NCH-1:0]  rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      m_id_q  <= '0;
      rdy_q   <= '0;
    end else begin
      started <= 1'b1;
      m_id_q  <= ring_m_id;
      rdy_q   <= dev_rdy & ch_en;
    end
  end

  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (ring_m_id == CH_W'(m_id_q - 1'b1)));
  p_dev_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vld != 2'b00) |=> (dev_vld == 2'b00));
  p_dev_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_vld[0] |-> rdy_q[dev_ch0]);
  p_req_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (ph == '0));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_ch) && $stable(mem_wr)));
  p_no_issue_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pend |=> !$rose(mem_req));
  p_apply_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_apply |=> !mem_pend);
  p_wr_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wr == !ch_out[mem_ch]));
endmodule

bind chan_sched_ring chsr_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_out(ch_out), .dev_rdy(dev_rdy),
  .mem_ack(mem_ack), .mem_req(mem_req), .mem_ch(mem_ch), .mem_wr(mem_wr),
  .dev_vld(dev_vld), .dev_ch0(dev_ch0), .ph(ph), .ring_m_id(ring_m_id),
  .mem_pend(mem_pend), .mem_apply(mem_apply));

// File: tb/sim_chan_sched_ring.sv
`timescale 1ns/1ps
module sim_chan_sched_ring;
  localparam int NCH = 16, DEPTH = 16, WORD = 4;

  typedef struct packed {
    logic [15:0] en, out, wide, rdy;
    logic [15:0] cycles;
    logic [7:0]  ackd;
  } scen_t;

  localparam scen_t SCN [4] = '{
    '{16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'd400, 8'd0},
    '{16'hFFFF, 16'h0000, 16'hAAAA, 16'hFFFF, 16'd400, 8'd2},
    '{16'hF0FF, 16'h33CC, 16'h0F0F, 16'h5A5A, 16'd800, 8'd20},
    '{16'h0010, 16'h0000, 16'h0010, 16'h0010, 16'd300, 8'd1}
  };

  logic clk = 0, rst_n = 0, mem_ack = 0;
  logic [NCH-1:0] ch_en = '0, ch_out = '0, ch_wide = '0, dev_rdy = '0;
  logic mem_req, mem_wr;
  logic [3:0] mem_ch, dev_ch0, dev_ch1;
  logic [1:0] dev_vld;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  chan_sched_ring #(.NCH(NCH), .DEPTH(DEPTH), .WORD(WORD)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_out(ch_out), .ch_wide(ch_wide),
    .dev_rdy(dev_rdy), .mem_ack(mem_ack), .mem_req(mem_req), .mem_ch(mem_ch),
    .mem_wr(mem_wr), .dev_vld(dev_vld), .dev_ch0(dev_ch0), .dev_ch1(dev_ch1));

  // Reference model, indexed by channel number; the slot of a channel follows from the phase.
  int mlvl [NCH];
  int ph, m_bp, m_bi, m_ch, wcnt;
  logic m_req, m_pend, m_wr;
  logic [1:0] m_dv;
  int m_dc [2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int want(input int l, input logic o);
    int v;
    if (o) v = DEPTH - l; else v = l;
    if (v < WORD) v = 0;
    return v;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) mlvl[c] = 0;
    ph = 0; m_bp = 0; m_bi = 0; m_ch = 0; wcnt = 0;
    m_req = 0; m_pend = 0; m_wr = 0; m_dv = 0; m_dc[0] = 0; m_dc[1] = 0;
  endtask

  task automatic model_step(input logic ack);
    int id0, p0, cb, nb, nbi;
    int nl [NCH];
    logic nreq, npend;
    id0 = (NCH - ph) % NCH;
    p0 = 0;
    if (ch_en[id0] && !((m_req || m_pend) && id0 == m_ch)) p0 = want(mlvl[id0], ch_out[id0]);
    cb = (ph == 0) ? 0 : m_bp;
    nb = cb; nbi = m_bi;
    if (p0 > 0 && (p0 > cb || (p0 == cb && id0 < m_bi))) begin nb = p0; nbi = id0; end
    nl = mlvl; nreq = m_req; npend = m_pend;
    if (m_pend && id0 == m_ch) begin
      nl[id0] = ch_out[id0] ? mlvl[id0] + WORD : mlvl[id0] - WORD;
      npend = 0;
    end
    if (m_req && ack) begin nreq = 0; npend = 1; end
    else if (ph == NCH - 1 && !m_req && !m_pend && nb > 0) begin
      nreq = 1; m_ch = nbi; m_wr = !ch_out[nbi];
    end
    for (int j = 0; j < 2; j++) begin
      int id, st;
      logic ok;
      id = (NCH / 2 + j - ph + NCH) % NCH;
      st = ch_wide[id] ? 2 : 1;
      ok = ch_out[id] ? (mlvl[id] >= st) : (mlvl[id] + st <= DEPTH);
      m_dv[j] = (ph % 2 == 0) && ch_en[id] && dev_rdy[id] && ok;
      if (m_dv[j]) begin
        nl[id] = ch_out[id] ? mlvl[id] - st : mlvl[id] + st;
        m_dc[j] = id;
      end
    end
    mlvl = nl; m_req = nreq; m_pend = npend;
    m_bp = nb; m_bi = nbi; ph = (ph + 1) % NCH;
  endtask

  task automatic compare();
    chk(mem_req === m_req, "R6 R8 request presence", int'(mem_req), int'(m_req));
    if (m_req) begin
      chk(mem_ch === 4'(m_ch), "R5 R6 selected channel", int'(mem_ch), m_ch);
      chk(mem_wr === m_wr, "R9 direction", int'(mem_wr), int'(m_wr));
    end
    chk(dev_vld === m_dv, "R3 R4 R10 device transfer", int'(dev_vld), int'(m_dv));
    if (m_dv[0]) chk(dev_ch0 === 4'(m_dc[0]), "R3 device port 0 channel", int'(dev_ch0), m_dc[0]);
    if (m_dv[1]) chk(dev_ch1 === 4'(m_dc[1]), "R3 device port 1 channel", int'(dev_ch1), m_dc[1]);
  endtask

  task automatic do_reset();
    rst_n = 0; mem_ack = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    // Directed: all output channels tied at priority 16, no device activity.
    ch_en = '1; ch_out = '1; ch_wide = '0; dev_rdy = '0;
    do_reset();
    chk(mem_req === 1'b0 && dev_vld === 2'b00, "R1 reset outputs", int'({mem_req, dev_vld}), 0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 15) chk(mem_req === 1'b0, "R2 R6 no request before rotation ends", int'(mem_req), 0);
    end
    chk(mem_req === 1'b1, "R2 R6 request after first rotation", int'(mem_req), 1);
    chk(mem_ch === 4'd0, "R6 tie goes to lowest channel", int'(mem_ch), 0);
    chk(mem_wr === 1'b0, "R9 output channel reads memory", int'(mem_wr), 0);
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    chk(mem_req === 1'b0, "R7 request drops after acknowledge", int'(mem_req), 0);
    for (int k = 18; k <= 48; k++) begin
      @(negedge clk);
      if (k == 32 || k == 47) chk(mem_req === 1'b0, "R8 no request while locked", int'(mem_req), 0);
    end
    chk(mem_req === 1'b1 && mem_ch === 4'd1, "R8 updated channel 0 loses to channel 1",
        int'(mem_ch), 1);

    // Table-driven scenarios against the reference model.
    for (int s = 0; s < 4; s++) begin
      ch_en = SCN[s].en; ch_out = SCN[s].out; ch_wide = SCN[s].wide; dev_rdy = SCN[s].rdy;
      do_reset();
      chk(mem_req === 1'b0 && dev_vld === 2'b00, "R1 reset outputs", int'({mem_req, dev_vld}), 0);
      for (int i = 0; i < int'(SCN[s].cycles); i++) begin
        logic a;
        compare();
        a = m_req && (wcnt >= int'(SCN[s].ackd));
        if (m_req) wcnt = a ? 0 : wcnt + 1; else wcnt = 0;
        mem_ack = a;
        model_step(a);
        @(negedge clk);
      end
      mem_ack = 0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule